// File: doc/BRIEF.md
# Programmable Duty Cycle Generator

This block produces one phase of a fixed-frequency drive waveform. A free-running period counter, clocked by the master clock, sets the switching frequency: one period lasts `PERIOD` clocks, 125 by default (a 25 MHz clock and 200 kHz switching). The waveform goes high at the start of each period and stays high for a number of clocks taken from an 8-bit duty register. A one-cycle strobe marks the first clock of every period.

A register value of zero does not mean 0% duty. It selects the default high time of half the period. Programmed values above the safe limit, `PERIOD*504/1000` clocks (63 by default, which is 50.4%), are clamped to that limit. The register is honoured only when the half-bridge mode input is high. In any other mode the waveform stays at the default duty. A value written to the register is taken up only at the next period boundary, so a period never contains a partial pulse. Power-down (active low) clears the register and stops the waveform. The enable input also stops the waveform, but it leaves the register as it is.

A small state machine drives the waveform. Its states are `ST_OFF` (stopped, output low), `ST_HIGH` (pulse active) and `ST_LOW` (rest of the period). It has these transitions:
- OFF→HIGH when running begins. This starts a period.
- HIGH→LOW when the latched high time has elapsed.
- LOW→HIGH at the last count of the period.
- Any state→OFF when power-down is asserted or enable is dropped.

Top module: `dpc_top`

## Requirements
- R1: While running, `period_start` pulses for one clock every `PERIOD` clocks, and `phase_out` is high in every clock in which `period_start` is high.
- R2: In half-bridge mode (`half_bridge`=1), a register value N with 1 ≤ N ≤ 63 gives exactly N high clocks per period.
- R3: In half-bridge mode, a register value of 0 gives the default high time of `PERIOD/2` clocks (62 by default).
- R4: In half-bridge mode, a register value above 63 (`PERIOD*504/1000`) gives exactly 63 high clocks.
- R5: With `half_bridge`=0, the register has no effect and every period has 62 high clocks.
- R6: A register write made during a period leaves that period unchanged. The new value governs the period that follows.
- R7: The register is 0 after reset and after any power-down. A full period after power-down is released shows the default high time.
- R8: While `pd_n` or `en` is low, `phase_out` and `period_start` are low. Once both are high, the next clock edge starts a period.
- R9: During and after reset, with `en` low, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| pd_n | input | 1 | Active-low power-down; stops the output and clears the register |
| en | input | 1 | Active-high drive enable |
| half_bridge | input | 1 | 1 selects half-bridge mode, where the duty register is used |
| wr_en | input | 1 | Duty register write strobe |
| wr_data | input | 8 | Duty register write value |
| phase_out | output | 1 | Phase waveform |
| period_start | output | 1 | One-clock strobe at the first clock of each period |

## Verification
A register write is latched at the edge on which `wr_en` is sampled. Its effect on the waveform is due only from the next period strobe, so after each write the bench skips any strobe already under way and measures the whole period that starts at the following strobe. The bench samples on falling edges. It counts high clocks and period length from one strobe up to the next, which makes the checks independent of where in the period the write landed. Start-up after `en` or `pd_n` rises is due one edge later: the strobe and a high output must both be visible at the first falling edge after that edge. Stopping is also due one edge after the input falls, so the low checks begin at the second falling edge.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } wave_state_t;

    function automatic int default_high(input int period);
        return period / 2;
    endfunction

    function automatic int max_high(input int period);
        return (period * 504) / 1000;
    endfunction

endpackage

// File: rtl/dpc_period_ctr.sv
module dpc_period_ctr #(
    parameter int PERIOD = 125,
    localparam int CNT_W = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || restart) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);                                             // R1

endmodule

// File: rtl/dpc_duty_reg.sv
module dpc_duty_reg
    import dpc_pkg::*;
#(
    parameter int PERIOD = 125,
    parameter int REG_W  = 8,
    localparam int CNT_W = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             half_bridge,
    input  logic             load,
    output logic [CNT_W-1:0] high_len
);

    localparam int CMP_W = (REG_W > CNT_W) ? REG_W : CNT_W;
    localparam logic [CNT_W-1:0] DEF_LEN = CNT_W'(default_high(PERIOD));
    localparam logic [CMP_W-1:0] MAX_LEN = CMP_W'(max_high(PERIOD));

    logic [REG_W-1:0] duty_q;
    logic [CMP_W-1:0] duty_ext;
    logic [CNT_W-1:0] eff_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_q <= '0;
        end else if (!pd_n) begin
            duty_q <= '0;
        end else if (wr_en) begin
            duty_q <= wr_data;
        end
    end

    assign duty_ext = CMP_W'(duty_q);

    always_comb begin
        if (!half_bridge || duty_q == '0) begin
            eff_len = DEF_LEN;
        end else if (duty_ext > MAX_LEN) begin
            eff_len = CNT_W'(MAX_LEN);
        end else begin
            eff_len = CNT_W'(duty_ext);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_len <= DEF_LEN;
        end else if (load) begin
            high_len <= eff_len;
        end
    end

    AST_REG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> duty_q == '0);                                  // R7
    AST_LATCH_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(high_len));                             // R6
    AST_DEFAULT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !half_bridge) |=> high_len == DEF_LEN);          // R5
    AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        CMP_W'(high_len) <= MAX_LEN || high_len == DEF_LEN);      // R4

endmodule

// File: rtl/dpc_wave_fsm.sv
module dpc_wave_fsm
    import dpc_pkg::*;
#(
    parameter int PERIOD = 125,
    localparam int CNT_W = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] high_len,
    output logic             restart,
    output logic             phase_out,
    output logic             period_start
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
    localparam int LIMIT = (max_high(PERIOD) > default_high(PERIOD)) ?
                           max_high(PERIOD) : default_high(PERIOD);

    wave_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_nx;
    logic             start_q;

    assign cnt_nx  = cnt + 1'b1;
    assign restart = run && (state_q == ST_OFF || cnt == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (run) state_d = ST_HIGH;
            ST_HIGH: begin
                if (!run)                   state_d = ST_OFF;
                else if (cnt == LAST)       state_d = ST_HIGH;
                else if (cnt_nx == high_len) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (!run)             state_d = ST_OFF;
                else if (cnt == LAST) state_d = ST_HIGH;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            start_q <= restart;
        end
    end

    always_comb begin
        phase_out    = (state_q == ST_HIGH);
        period_start = start_q;
    end

    AST_HIGH_WITHIN_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HIGH |-> int'(cnt) < LIMIT);                // R4
    AST_STROBE_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> state_q == ST_HIGH && cnt == '0);             // R1

endmodule

// File: rtl/dpc_top.sv
module dpc_top #(
    parameter int PERIOD = 125,
    parameter int REG_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             en,
    input  logic             half_bridge,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             phase_out,
    output logic             period_start
);

    localparam int CNT_W = $clog2(PERIOD);

    logic             run;
    logic             restart;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] high_len;

    assign run = pd_n && en;

    dpc_period_ctr #(.PERIOD(PERIOD)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .cnt     (cnt)
    );

    dpc_duty_reg #(.PERIOD(PERIOD), .REG_W(REG_W)) u_duty (
        .clk         (clk),
        .rst_n       (rst_n),
        .pd_n        (pd_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .half_bridge (half_bridge),
        .load        (restart),
        .high_len    (high_len)
    );

    dpc_wave_fsm #(.PERIOD(PERIOD)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .run          (run),
        .cnt          (cnt),
        .high_len     (high_len),
        .restart      (restart),
        .phase_out    (phase_out),
        .period_start (period_start)
    );

    AST_STOP_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !phase_out && !period_start);                    // R8
    AST_STROBE_WITH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> phase_out);                              // R1

endmodule

// File: tb/dpc_top_bench.sv
`timescale 1ns/1ps
module dpc_top_bench;

    localparam int PERIOD = 125;
    localparam int DEF    = PERIOD / 2;
    localparam int MAXH   = (PERIOD * 504) / 1000;

    typedef struct packed {
        logic       hb;
        logic [7:0] val;
        logic [7:0] exp;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [0:NVEC-1] = '{
        '{1'b1, 8'd0,   8'd62},
        '{1'b1, 8'd1,   8'd1},
        '{1'b1, 8'd13,  8'd13},
        '{1'b1, 8'd62,  8'd62},
        '{1'b1, 8'd63,  8'd63},
        '{1'b1, 8'd64,  8'd63},
        '{1'b1, 8'd255, 8'd63},
        '{1'b0, 8'd13,  8'd62},
        '{1'b0, 8'd200, 8'd62},
        '{1'b1, 8'd100, 8'd63}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_n = 1'b1;
    logic en = 1'b0;
    logic half_bridge = 1'b1;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic phase_out, period_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dpc_top #(.PERIOD(PERIOD), .REG_W(8)) u_dpc_top (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .en(en),
        .half_bridge(half_bridge), .wr_en(wr_en), .wr_data(wr_data),
        .phase_out(phase_out), .period_start(period_start)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic hb, input logic [7:0] v);
        if (!hb) return "R5";
        if (v == 0) return "R3";
        if (int'(v) > MAXH) return "R4";
        return "R2";
    endfunction

    task automatic write_reg(input logic [7:0] v);
        wr_data = v;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_strobe();
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!period_start && guard < 1000);
    endtask

    task automatic count_rest(inout int hi, inout int len);
        do begin
            @(negedge clk);
            if (!period_start) begin
                if (phase_out) hi++;
                len++;
            end
        end while (!period_start && len < 1000);
    endtask

    task automatic measure(output int hi, output int len);
        wait_strobe();
        hi = phase_out ? 1 : 0;
        len = 1;
        count_rest(hi, len);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int hi, len;
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 phase in reset", phase_out, 0);
        check("R9 strobe in reset", period_start, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 phase after reset", phase_out, 0);
        check("R9 strobe after reset", period_start, 0);

        // R8: start one edge after enable
        en = 1'b1;
        @(negedge clk);
        check("R8 start strobe", period_start, 1);
        check("R1 phase at strobe", phase_out, 1);
        // R7: register zero after reset gives default
        measure(hi, len);
        check("R7 default after reset", hi, DEF);
        check("R1 period length", len, PERIOD);

        // Vector table: R2 R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            half_bridge = VEC[i].hb;
            write_reg(VEC[i].val);
            measure(hi, len);
            check(tag_of(VEC[i].hb, VEC[i].val), hi, int'(VEC[i].exp));
            check("R1 period length", len, PERIOD);
        end

        // R6: mid-period write keeps current period
        half_bridge = 1'b1;
        write_reg(8'd63);
        measure(hi, len);
        check("R6 setup", hi, 63);
        wait_strobe();
        hi = phase_out ? 1 : 0;
        len = 1;
        wr_data = 8'd13;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (phase_out) hi++;
        len++;
        count_rest(hi, len);
        check("R6 current period unchanged", hi, 63);
        hi = phase_out ? 1 : 0;
        len = 1;
        count_rest(hi, len);
        check("R6 next period new value", hi, 13);

        // R8 / R7: power-down
        pd_n = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check("R8 low in power-down", phase_out | period_start, 0);
        end
        pd_n = 1'b1;
        @(negedge clk);
        check("R8 start after power-down", period_start, 1);
        measure(hi, len);
        check("R7 register cleared by power-down", hi, DEF);

        // R8: enable low
        write_reg(8'd20);
        en = 1'b0;
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R8 low while disabled", phase_out | period_start, 0);
        end
        en = 1'b1;
        @(negedge clk);
        check("R8 restart strobe", period_start, 1);
        hi = phase_out ? 1 : 0;
        len = 1;
        count_rest(hi, len);
        check("R8 register kept across disable", hi, 20);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule